// File: doc/BRIEF.md
# Impedance Compensation Blocking Timer

This block schedules the periodic driver-impedance recalibration of a memory channel. While enabled it counts refresh-interval ticks. Once a programmed number of them has gone by, it opens a window of a programmed number of clocks during which the channel scheduler must issue no DRAM command. Inside that window it gives two single-clock strobes. The first tells the command-path drivers to take new compensation codes, at a programmable clock offset from the window start. The second tells the data-path drivers to take theirs, on the last clock of the window.

The interval field holds the desired number of refresh intervals minus one. Ticks that arrive while a window is open are not counted, and the interval count starts again from zero when a window closes. Window length and strobe offset are captured when a window opens, so reprogramming them mid-window does not disturb the window in progress. Clearing the enable lets an open window finish normally and prevents any later window.

Top module: `imp_comp_timer`

## Requirements
- R1: While the enable input is low, no window opens: block_cmds, cmd_update and data_update stay low whatever refresh ticks arrive, and the interval count is held at zero.
- R2: With interval setting N (4 bits, 0 to 15), a window opens on the clock after the (N+1)-th refresh tick counted since the count last restarted; the earlier N ticks open no window.
- R3: A window holds block_cmds high for exactly L consecutive clocks, where L is the 6-bit length setting, starting on the clock after the tick that completes the interval.
- R4: data_update is high for exactly one clock per window, on the last clock that block_cmds is high (window clock L-1, counting the first window clock as 0).
- R5: cmd_update is high for exactly one clock per window, on window clock K, where K is the 6-bit offset setting, whenever K is less than L.
- R6: When K is greater than or equal to L, no cmd_update pulse occurs in that window; the window itself and its data_update are unchanged.
- R7: A length setting of 0 opens no window when the interval completes; the interval count still restarts from zero.
- R8: Refresh ticks that arrive while block_cmds is high are ignored, and the interval count restarts from zero when the window ends.
- R9: Clearing the enable during a window lets that window run to its full length with its strobes, and no later window opens while the enable stays low.
- R10: After reset all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enables periodic compensation windows |
| cfg_interval | input | 4 | Refresh intervals between windows, minus one |
| cfg_length | input | 6 | Window length in clocks |
| cfg_cmd_offset | input | 6 | Window clock on which cmd_update pulses |
| refresh_tick | input | 1 | One-clock pulse per refresh interval |
| block_cmds | output | 1 | High while DRAM commands must be held off |
| cmd_update | output | 1 | Command-path compensation update strobe |
| data_update | output | 1 | Data-path compensation update strobe |

## Verification
On every cycle the assertions check that both strobes fall inside a window, that each strobe lasts a single clock, that a window always ends right after its data strobe, that a window never opens with zero length or without the enable, and that the interval count is zero after any window clock. Only the bench scenarios show the exact spacing: that the window follows the (N+1)-th tick, that it lasts exactly L clocks, that the command strobe lands on clock K, and that ticks during a window, a zero length, or a mid-window disable leave the following interval as required.

// File: rtl/imp_comp_pkg.sv
package imp_comp_pkg;

   // Default field widths of the configuration inputs.
   localparam int unsigned DEF_IVL_W = 4;
   localparam int unsigned DEF_LEN_W = 6;

   // Phase of the compensation sequencer.
   typedef enum logic {
      PH_COUNT = 1'b0,
      PH_BLOCK = 1'b1
   } comp_phase_e;

endpackage

// File: rtl/imp_comp_interval.sv
module imp_comp_interval #(
   parameter int unsigned IVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [IVL_W-1:0] interval,
   input  logic             tick,
   input  logic             hold,
   output logic             expire
);

   if (IVL_W < 1 || IVL_W > 16) begin : g_bad_ivl_w
      $error("imp_comp_interval: IVL_W must be 1..16");
   end

   logic [IVL_W-1:0] tick_cnt;
   logic             counting;
   logic             reached;

   assign counting = enable && !hold;
   // A count at or above the setting completes the interval, so a
   // setting lowered mid-count does not force a wrap through all values.
   assign reached  = (tick_cnt >= interval);
   assign expire   = counting && tick && reached;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (!counting) begin
         tick_cnt <= '0;
      end else if (tick) begin
         tick_cnt <= reached ? '0 : tick_cnt + 1'b1;
      end
   end

   // R8: after any window clock the count has restarted from zero
   p_restart_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold) |-> (tick_cnt == '0));

   // R1: with the enable low the count is held at zero
   p_idle_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!enable) |-> (tick_cnt == '0));

endmodule

// File: rtl/imp_comp_window.sv
module imp_comp_window #(
   parameter int unsigned LEN_W       = 6,
   parameter bit          CAPTURE_CFG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] length,
   input  logic [LEN_W-1:0] offset,
   output logic             active,
   output logic [LEN_W-1:0] win_cnt,
   output logic [LEN_W-1:0] len_eff,
   output logic [LEN_W-1:0] off_eff
);
   import imp_comp_pkg::*;

   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len_w
      $error("imp_comp_window: LEN_W must be 1..16");
   end

   comp_phase_e      phase;
   logic             at_end;
   logic             opening;

   assign active  = (phase == PH_BLOCK);
   assign opening = !active && start && (length != '0);
   assign at_end  = active && (win_cnt == len_eff - 1'b1);

   if (CAPTURE_CFG) begin : g_capture
      logic [LEN_W-1:0] len_q;
      logic [LEN_W-1:0] off_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            len_q <= '0;
            off_q <= '0;
         end else if (opening) begin
            len_q <= length;
            off_q <= offset;
         end
      end
      assign len_eff = len_q;
      assign off_eff = off_q;
   end else begin : g_live
      assign len_eff = length;
      assign off_eff = offset;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_COUNT;
         win_cnt <= '0;
      end else if (opening) begin
         phase   <= PH_BLOCK;
         win_cnt <= '0;
      end else if (at_end) begin
         phase   <= PH_COUNT;
         win_cnt <= '0;
      end else if (active) begin
         win_cnt <= win_cnt + 1'b1;
      end
   end

   // R7: a window never runs with a zero length
   p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (len_eff != '0));

   // R3: the window counter never passes the last window clock
   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (win_cnt < len_eff));

endmodule

// File: rtl/imp_comp_strobes.sv
module imp_comp_strobes #(
   parameter int unsigned LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [LEN_W-1:0] win_cnt,
   input  logic [LEN_W-1:0] len_eff,
   input  logic [LEN_W-1:0] off_eff,
   output logic             cmd_strobe,
   output logic             data_strobe
);

   // The window counter never reaches len_eff, so an offset at or
   // beyond the length never matches and gives no command strobe.
   assign cmd_strobe  = active && (win_cnt == off_eff);
   assign data_strobe = active && (win_cnt == len_eff - 1'b1);

   // R5: the command strobe lies inside a window
   p_cmd_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |-> active);

   // R5: the command strobe lasts one clock
   p_cmd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |=> !cmd_strobe);

   // R6: a command strobe only occurs when the offset fits the window
   p_cmd_offset_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |-> (off_eff < len_eff));

   // R4: the window closes right after the data strobe
   p_data_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_strobe |=> !active);

endmodule

// File: rtl/imp_comp_timer.sv
module imp_comp_timer #(
   parameter int unsigned IVL_W       = imp_comp_pkg::DEF_IVL_W,
   parameter int unsigned LEN_W       = imp_comp_pkg::DEF_LEN_W,
   parameter bit          CAPTURE_CFG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic [IVL_W-1:0] cfg_interval,
   input  logic [LEN_W-1:0] cfg_length,
   input  logic [LEN_W-1:0] cfg_cmd_offset,
   input  logic             refresh_tick,
   output logic             block_cmds,
   output logic             cmd_update,
   output logic             data_update
);

   logic             win_active;
   logic             ivl_expire;
   logic [LEN_W-1:0] win_cnt;
   logic [LEN_W-1:0] len_eff;
   logic [LEN_W-1:0] off_eff;

   imp_comp_interval #(.IVL_W(IVL_W)) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (cfg_enable),
      .interval (cfg_interval),
      .tick     (refresh_tick),
      .hold     (win_active),
      .expire   (ivl_expire)
   );

   imp_comp_window #(.LEN_W(LEN_W), .CAPTURE_CFG(CAPTURE_CFG)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (ivl_expire),
      .length  (cfg_length),
      .offset  (cfg_cmd_offset),
      .active  (win_active),
      .win_cnt (win_cnt),
      .len_eff (len_eff),
      .off_eff (off_eff)
   );

   imp_comp_strobes #(.LEN_W(LEN_W)) u_strobes (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (win_active),
      .win_cnt     (win_cnt),
      .len_eff     (len_eff),
      .off_eff     (off_eff),
      .cmd_strobe  (cmd_update),
      .data_strobe (data_update)
   );

   assign block_cmds = win_active;

   // R1: a window only opens while the enable is high
   p_open_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(block_cmds) |-> $past(cfg_enable));

   // R4: every window ends with its data strobe
   p_close_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(block_cmds) |-> $past(data_update));

   // R4: the data strobe lies inside a window
   p_data_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_update |-> block_cmds);

endmodule

// File: tb/imp_comp_timer_test.sv
module imp_comp_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0;
   logic [3:0] cfg_interval = '0;
   logic [5:0] cfg_length = 6'd9;
   logic [5:0] cfg_cmd_offset = 6'd2;
   logic       refresh_tick = 1'b0;
   logic       block_cmds;
   logic       cmd_update;
   logic       data_update;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   imp_comp_timer uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_enable     (cfg_enable),
      .cfg_interval   (cfg_interval),
      .cfg_length     (cfg_length),
      .cfg_cmd_offset (cfg_cmd_offset),
      .refresh_tick   (refresh_tick),
      .block_cmds     (block_cmds),
      .cmd_update     (cmd_update),
      .data_update    (data_update)
   );

   // Vector: {interval[15:12], length[11:6], offset[5:0]}
   localparam int NVEC = 7;
   localparam logic [15:0] VEC [NVEC] = '{
      {4'd0,  6'd9,  6'd2},
      {4'd3,  6'd31, 6'd15},
      {4'd1,  6'd5,  6'd7},
      {4'd2,  6'd1,  6'd0},
      {4'd0,  6'd4,  6'd4},
      {4'd15, 6'd3,  6'd1},
      {4'd1,  6'd63, 6'd62}
   };

   task automatic check(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
      end
   endtask

   // Called at a negedge; drives one tick clock, returns at the next negedge.
   task automatic pulse_tick();
      refresh_tick = 1'b1;
      @(negedge clk);
      refresh_tick = 1'b0;
   endtask

   task automatic idle_cycles(input int n, input string what);
      for (int i = 0; i < n; i++) begin
         check(block_cmds, 1'b0, what);
         check(cmd_update | data_update, 1'b0, what);
         @(negedge clk);
      end
   endtask

   // Called at the negedge of window clock 0; walks the window and two more clocks.
   task automatic walk_window(input int len, input int off, input bit ticks_inside);
      for (int c = 0; c < len + 2; c++) begin
         check(block_cmds, c < len, $sformatf("R3 block clk %0d len %0d", c, len));
         check(data_update, c == len - 1, $sformatf("R4 data clk %0d len %0d", c, len));
         if (off >= len)
            check(cmd_update, 1'b0, $sformatf("R6 cmd clk %0d off %0d len %0d", c, off, len));
         else
            check(cmd_update, c == off, $sformatf("R5 cmd clk %0d off %0d", c, off));
         if (ticks_inside && c < len - 1 && (c % 3) == 1)
            pulse_tick();
         else
            @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(block_cmds, 1'b0, "R10 block after reset");
      check(cmd_update, 1'b0, "R10 cmd after reset");
      check(data_update, 1'b0, "R10 data after reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: disabled, ticks do nothing
      for (int i = 0; i < 6; i++) begin
         pulse_tick();
         idle_cycles(2, "R1 disabled");
      end

      // Table of interval/length/offset vectors
      cfg_enable = 1'b1;
      for (int v = 0; v < NVEC; v++) begin
         cfg_interval   = VEC[v][15:12];
         cfg_length     = VEC[v][11:6];
         cfg_cmd_offset = VEC[v][5:0];
         @(negedge clk);
         for (int t = 0; t < int'(VEC[v][15:12]); t++) begin
            pulse_tick();
            idle_cycles(2, "R2 before interval done");
         end
         pulse_tick();
         walk_window(int'(VEC[v][11:6]), int'(VEC[v][5:0]), 1'b0);
      end

      // R7: zero length opens nothing and restarts the count
      cfg_interval = 4'd0; cfg_length = 6'd0; cfg_cmd_offset = 6'd0;
      @(negedge clk);
      pulse_tick();
      idle_cycles(4, "R7 zero length");
      cfg_interval = 4'd1; cfg_length = 6'd3;
      @(negedge clk);
      pulse_tick();
      idle_cycles(3, "R7 count restarted");
      pulse_tick();
      walk_window(3, 0, 1'b0);

      // R8: ticks inside a window are ignored, count restarts at window end
      cfg_interval = 4'd1; cfg_length = 6'd10; cfg_cmd_offset = 6'd0;
      @(negedge clk);
      pulse_tick();
      idle_cycles(1, "R8 first tick");
      pulse_tick();
      walk_window(10, 0, 1'b1);
      pulse_tick();
      idle_cycles(3, "R8 one tick after window");
      pulse_tick();
      walk_window(10, 0, 1'b0);

      // R9: disable mid-window; window completes, none follow
      cfg_interval = 4'd0; cfg_length = 6'd8; cfg_cmd_offset = 6'd5;
      @(negedge clk);
      pulse_tick();
      for (int c = 0; c < 10; c++) begin
         check(block_cmds, c < 8, $sformatf("R9 block clk %0d", c));
         check(data_update, c == 7, $sformatf("R9 data clk %0d", c));
         check(cmd_update, c == 5, $sformatf("R9 cmd clk %0d", c));
         if (c == 2) cfg_enable = 1'b0;
         @(negedge clk);
      end
      for (int i = 0; i < 4; i++) begin
         pulse_tick();
         idle_cycles(2, "R9 no window after disable");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule